// File: doc/BRIEF.md
# Indexed-Colour Display Register Slave

This block is the register side of an 8-bit indexed colour display controller. A host reaches it with whole 32-bit words over a plain valid/write/address/data bus. The address map is sparse. The block holds:

- a 256-entry RGB lookup table for pixel colours,
- a three-entry RGB table for cursor colours,
- a 512-word cursor bitmap,
- the cursor location,
- a 32-bit control word,
- the screen start offset,
- the active width and height.

Every decoded setting is presented as a steady output to the pixel pipeline. The pixel pipeline reads the three tables through their own index ports, which are independent of the host bus.

A refresh interrupt is set by a pulse from the display side and is dropped by any host write. A one-cycle redraw pulse follows every host write that alters the picture, so the display side knows to repaint the whole frame. Writes to the video timing addresses are taken and discarded. A write to the reset address returns all state to zero.

Top module: `fbctl_regs`

## Requirements
- R1: After the asynchronous reset, the following are all zero: irq, redraw, bus_rvalid, width_px, height_px, ctrl_word, screen_start, the cursor coordinates and every table entry. pix_depth is 1 and cursor_on is 1.
- R2: Writing v to byte address 0x118 sets width_px to 4·v, keeping the low DIM_W−2 bits of v. Reading 0x118 returns width_px / 4.
- R3: Writing v to 0x150 sets height_px to v / 2, using bits DIM_W:1 of v. Reading 0x150 returns height_px · 2.
- R4: Address 0x300 holds the control word, which reads back in full. Bits 22:20 select pix_depth as follows: 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, 6→0, 7→0. Bit 10 drives force_blank. Bit 23 set clears cursor_on.
- R5: The colour table occupies 0x800–0xFFF. The entry index is (address − 0x800) >> 3. A write stores red from bits 23:16, green from 15:8 and blue from 7:0, and pix_rgb presents the entry selected by pix_index in that same packing. Reads of this region return 0.
- R6: The cursor colour table starts at 0x508 and has three entries, with index (address − 0x508) >> 3. It uses the same RGB packing and reads back on the bus. csr_rgb presents entry csr_sel, and csr_sel = 3 gives 0.
- R7: The cursor bitmap occupies 0x1000–0x1FFF. Its index is (address − 0x1000) >> 3, and it stores bits 15:0 of the written word. It reads back zero-extended and is presented on pat_word for pat_index.
- R8: A write to 0x638 sets cursor_x from bits 23:12 and cursor_y from bits 11:0. A write to 0x400 sets screen_start. Both addresses read as 0.
- R9: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change no output and no register. Reads of unmapped addresses return 0.
- R10: bus_rdata and bus_rvalid are registered. bus_rvalid is high in exactly the cycle after each read request.
- R11: irq rises at the clock edge after refresh_raise. It falls at the edge after any write. A write in the same cycle as refresh_raise wins.
- R12: A write to 0x100000 clears every register and table entry and lowers irq.
- R13: redraw is high for the single cycle after a write to the colour table, the cursor colour table, the bitmap, the control word, the screen start or the reset address. It stays low after any other access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| refresh_raise | input | 1 | Display-side interrupt set pulse |
| irq | output | 1 | Refresh interrupt |
| redraw | output | 1 | Picture-changing write pulse |
| pix_index | input | 8 | Colour table lookup index |
| pix_rgb | output | 24 | Colour table entry |
| pat_index | input | 9 | Cursor bitmap lookup index |
| pat_word | output | 16 | Cursor bitmap word |
| csr_sel | input | 2 | Cursor colour select |
| csr_rgb | output | 24 | Cursor colour entry |
| width_px | output | DIM_W | Active width in pixels |
| height_px | output | DIM_W | Active height in lines |
| ctrl_word | output | 32 | Control word |
| pix_depth | output | 5 | Decoded bits per pixel |
| force_blank | output | 1 | Blank the display |
| cursor_on | output | 1 | Cursor enabled |
| cursor_x | output | 12 | Cursor column |
| cursor_y | output | 12 | Cursor row |
| screen_start | output | 32 | Screen start offset |

## Verification
All results are due one rising edge after the request that causes them:

- Register and table state, and hence every exported setting and lookup port, updates at the edge that accepts a write.
- bus_rdata and bus_rvalid appear one edge after a read request.
- redraw is high only for the cycle that follows a picture-changing write.
- irq moves one edge after refresh_raise or a write.

The bench changes inputs on falling edges and samples exactly one falling edge later. It then samples one further falling edge to confirm that pulses have dropped and that held values have stayed put.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

  localparam int BUS_AW      = 21;
  localparam int ENTRY_SHIFT = 3;
  localparam int RGB_W       = 24;
  localparam int PAT_W       = 16;
  localparam int CUR_W       = 12;
  localparam int DEPTH_W     = 5;

  localparam int unsigned OFS_WIDTH  = 32'h0000_0118;
  localparam int unsigned OFS_HEIGHT = 32'h0000_0150;
  localparam int unsigned OFS_CTRL   = 32'h0000_0300;
  localparam int unsigned OFS_START  = 32'h0000_0400;
  localparam int unsigned OFS_CPOS   = 32'h0000_0638;
  localparam int unsigned OFS_RESET  = 32'h0010_0000;
  localparam int unsigned CPAL_BASE  = 32'h0000_0508;
  localparam int unsigned PAL_BASE   = 32'h0000_0800;
  localparam int unsigned PAL_SPAN   = 32'h0000_0800;
  localparam int unsigned PAT_BASE   = 32'h0000_1000;
  localparam int unsigned PAT_SPAN   = 32'h0000_1000;

  localparam int CPAL_DEPTH = 3;
  localparam int PAL_DEPTH  = PAL_SPAN >> ENTRY_SHIFT;
  localparam int PAT_DEPTH  = PAT_SPAN >> ENTRY_SHIFT;
  localparam int CPAL_SPAN  = CPAL_DEPTH << ENTRY_SHIFT;
  localparam int PAL_IW     = $clog2(PAL_DEPTH);
  localparam int PAT_IW     = $clog2(PAT_DEPTH);
  localparam int CPAL_IW    = $clog2(CPAL_DEPTH);
  localparam int IDX_W      = PAT_IW;

  localparam int CTL_BLANK_BIT  = 10;
  localparam int CTL_DEPTH_LSB  = 20;
  localparam int CTL_NOCURS_BIT = 23;

  typedef enum logic [3:0] {
    RG_NONE, RG_IGNORE, RG_WIDTH, RG_HEIGHT, RG_CTRL, RG_START,
    RG_CPAL, RG_CPOS, RG_PAL, RG_PAT, RG_RESET
  } region_e;

  typedef struct packed {
    region_e            region;
    logic [IDX_W-1:0]   idx;
  } dec_t;

  function automatic logic [DEPTH_W-1:0] depth_lookup(input logic [2:0] sel);
    case (sel)
      3'd0:    depth_lookup = 5'd1;
      3'd1:    depth_lookup = 5'd2;
      3'd2:    depth_lookup = 5'd4;
      3'd3:    depth_lookup = 5'd8;
      3'd4:    depth_lookup = 5'd15;
      3'd5:    depth_lookup = 5'd16;
      default: depth_lookup = 5'd0;
    endcase
  endfunction

  function automatic logic is_timing_addr(input logic [31:0] a);
    case (a)
      32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130, 32'h138,
      32'h140, 32'h148, 32'h158, 32'h160, 32'h168, 32'h170, 32'h200:
        is_timing_addr = 1'b1;
      default:
        is_timing_addr = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
  import fbctl_pkg::*;
#(
  parameter int ADDR_W = BUS_AW
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  logic [31:0] a32;

  always_comb begin
    a32        = 32'(addr);
    dec.region = RG_NONE;
    dec.idx    = '0;
    if (a32 >= PAL_BASE && a32 < PAL_BASE + PAL_SPAN) begin
      dec.region = RG_PAL;
      dec.idx    = IDX_W'((a32 - PAL_BASE) >> ENTRY_SHIFT);
    end else if (a32 >= PAT_BASE && a32 < PAT_BASE + PAT_SPAN) begin
      dec.region = RG_PAT;
      dec.idx    = IDX_W'((a32 - PAT_BASE) >> ENTRY_SHIFT);
    end else if (a32 >= CPAL_BASE && a32 < CPAL_BASE + CPAL_SPAN) begin
      dec.region = RG_CPAL;
      dec.idx    = IDX_W'((a32 - CPAL_BASE) >> ENTRY_SHIFT);
    end else if (a32 == OFS_WIDTH) begin
      dec.region = RG_WIDTH;
    end else if (a32 == OFS_HEIGHT) begin
      dec.region = RG_HEIGHT;
    end else if (a32 == OFS_CTRL) begin
      dec.region = RG_CTRL;
    end else if (a32 == OFS_START) begin
      dec.region = RG_START;
    end else if (a32 == OFS_CPOS) begin
      dec.region = RG_CPOS;
    end else if (a32 == OFS_RESET) begin
      dec.region = RG_RESET;
    end else if (is_timing_addr(a32)) begin
      dec.region = RG_IGNORE;
    end
  end

endmodule

// File: rtl/fbctl_store.sv
module fbctl_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int NRD   = 1,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    we,
  input  logic [IW-1:0]           widx,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][IW-1:0]  ridx,
  output logic [NRD-1:0][DW-1:0]  rdata
);

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic          ent_en;
    logic [DW-1:0] ent_d;

    always_comb begin
      ent_en = clr | (we && (widx == IW'(i)));
      ent_d  = clr ? '0 : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[i] <= '0;
      else if (ent_en) mem_q[i] <= ent_d;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    if (DEPTH == (1 << IW)) begin : g_full
      always_comb rdata[p] = mem_q[ridx[p]];
    end else begin : g_part
      always_comb rdata[p] = (32'(ridx[p]) < DEPTH) ? mem_q[ridx[p]] : '0;
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mem_q[0] == '0)); // R12

endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
  import fbctl_pkg::*;
#(
  parameter int ADDR_W = BUS_AW,
  parameter int DIM_W  = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic                refresh_raise,
  output logic                irq,
  output logic                redraw,
  input  logic [PAL_IW-1:0]   pix_index,
  output logic [RGB_W-1:0]    pix_rgb,
  input  logic [PAT_IW-1:0]   pat_index,
  output logic [PAT_W-1:0]    pat_word,
  input  logic [CPAL_IW-1:0]  csr_sel,
  output logic [RGB_W-1:0]    csr_rgb,
  output logic [DIM_W-1:0]    width_px,
  output logic [DIM_W-1:0]    height_px,
  output logic [31:0]         ctrl_word,
  output logic [DEPTH_W-1:0]  pix_depth,
  output logic                force_blank,
  output logic                cursor_on,
  output logic [CUR_W-1:0]    cursor_x,
  output logic [CUR_W-1:0]    cursor_y,
  output logic [31:0]         screen_start
);

  localparam int CPOS_W = 2 * CUR_W;

  dec_t dec;

  fbctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  logic wr_req, rd_req, is_reset;
  logic pal_we, pat_we, cpal_we;
  logic ctrl_en, start_en, cpos_en, width_en, height_en;
  logic [31:0]        ctrl_d, start_d, rdata_d;
  logic [CPOS_W-1:0]  cpos_d;
  logic [DIM_W-1:0]   width_d, height_d;
  logic               irq_d, redraw_d;

  logic [31:0]        ctrl_q, start_q, rdata_q;
  logic [CPOS_W-1:0]  cpos_q;
  logic [DIM_W-1:0]   width_q, height_q;
  logic               irq_q, redraw_q, rvalid_q;

  logic [0:0][RGB_W-1:0] pal_rd;
  logic [1:0][PAT_W-1:0] pat_rd;
  logic [1:0][RGB_W-1:0] cpal_rd;

  fbctl_store #(.DEPTH(PAL_DEPTH), .DW(RGB_W), .NRD(1)) u_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (is_reset),
    .we    (pal_we),
    .widx  (dec.idx[PAL_IW-1:0]),
    .wdata (bus_wdata[RGB_W-1:0]),
    .ridx  (pix_index),
    .rdata (pal_rd)
  );

  fbctl_store #(.DEPTH(PAT_DEPTH), .DW(PAT_W), .NRD(2)) u_pat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (is_reset),
    .we    (pat_we),
    .widx  (dec.idx[PAT_IW-1:0]),
    .wdata (bus_wdata[PAT_W-1:0]),
    .ridx  ({dec.idx[PAT_IW-1:0], pat_index}),
    .rdata (pat_rd)
  );

  fbctl_store #(.DEPTH(CPAL_DEPTH), .DW(RGB_W), .NRD(2)) u_cpal (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (is_reset),
    .we    (cpal_we),
    .widx  (dec.idx[CPAL_IW-1:0]),
    .wdata (bus_wdata[RGB_W-1:0]),
    .ridx  ({dec.idx[CPAL_IW-1:0], csr_sel}),
    .rdata (cpal_rd)
  );

  // next-state logic
  always_comb begin
    wr_req   = bus_valid &  bus_write;
    rd_req   = bus_valid & ~bus_write;
    is_reset = wr_req && (dec.region == RG_RESET);

    pal_we    = wr_req && (dec.region == RG_PAL);
    pat_we    = wr_req && (dec.region == RG_PAT);
    cpal_we   = wr_req && (dec.region == RG_CPAL);
    ctrl_en   = is_reset | (wr_req && (dec.region == RG_CTRL));
    start_en  = is_reset | (wr_req && (dec.region == RG_START));
    cpos_en   = is_reset | (wr_req && (dec.region == RG_CPOS));
    width_en  = is_reset | (wr_req && (dec.region == RG_WIDTH));
    height_en = is_reset | (wr_req && (dec.region == RG_HEIGHT));

    ctrl_d   = is_reset ? '0 : bus_wdata;
    start_d  = is_reset ? '0 : bus_wdata;
    cpos_d   = is_reset ? '0 : bus_wdata[CPOS_W-1:0];
    width_d  = is_reset ? '0 : {bus_wdata[DIM_W-3:0], 2'b00};
    height_d = is_reset ? '0 : bus_wdata[DIM_W:1];

    if (wr_req)             irq_d = 1'b0;
    else if (refresh_raise) irq_d = 1'b1;
    else                    irq_d = irq_q;

    redraw_d = wr_req && (dec.region inside
                 {RG_PAL, RG_CPAL, RG_PAT, RG_CTRL, RG_START, RG_RESET});

    case (dec.region)
      RG_WIDTH:  rdata_d = 32'(width_q >> 2);
      RG_HEIGHT: rdata_d = 32'({height_q, 1'b0});
      RG_CTRL:   rdata_d = ctrl_q;
      RG_CPAL:   rdata_d = 32'(cpal_rd[1]);
      RG_PAT:    rdata_d = 32'(pat_rd[1]);
      default:   rdata_d = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      start_q  <= '0;
      cpos_q   <= '0;
      width_q  <= '0;
      height_q <= '0;
      irq_q    <= 1'b0;
      redraw_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (ctrl_en)   ctrl_q   <= ctrl_d;
      if (start_en)  start_q  <= start_d;
      if (cpos_en)   cpos_q   <= cpos_d;
      if (width_en)  width_q  <= width_d;
      if (height_en) height_q <= height_d;
      if (rd_req)    rdata_q  <= rdata_d;
      irq_q    <= irq_d;
      redraw_q <= redraw_d;
      rvalid_q <= rd_req;
    end
  end

  always_comb begin
    bus_rdata    = rdata_q;
    bus_rvalid   = rvalid_q;
    irq          = irq_q;
    redraw       = redraw_q;
    pix_rgb      = pal_rd[0];
    pat_word     = pat_rd[0];
    csr_rgb      = cpal_rd[0];
    width_px     = width_q;
    height_px    = height_q;
    ctrl_word    = ctrl_q;
    pix_depth    = depth_lookup(ctrl_q[CTL_DEPTH_LSB +: 3]);
    force_blank  = ctrl_q[CTL_BLANK_BIT];
    cursor_on    = ~ctrl_q[CTL_NOCURS_BIT];
    cursor_x     = cpos_q[CPOS_W-1:CUR_W];
    cursor_y     = cpos_q[CUR_W-1:0];
    screen_start = start_q;
  end

  AST_WRITE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |=> !irq); // R11
  AST_RAISE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_raise && !(bus_valid && bus_write)) |=> irq); // R11
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid); // R10
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && dec.region == RG_RESET) |=>
      (ctrl_word == '0 && width_px == '0 && height_px == '0 && !irq)); // R12
  AST_REDRAW_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    redraw |-> $past(bus_valid && bus_write)); // R13

endmodule

// File: tb/tb_fbctl_regs.sv
module tb_fbctl_regs;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic        wr;
    logic [20:0] addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  // reads carry the expected value in the data field
  localparam vec_t VECS [25] = '{
    '{1'b1, 21'h118,  32'h0000_0140, 4'd2},   // R2
    '{1'b0, 21'h118,  32'h0000_0140, 4'd2},
    '{1'b1, 21'h150,  32'h0000_03C1, 4'd3},   // R3 odd value drops bit 0
    '{1'b0, 21'h150,  32'h0000_03C0, 4'd3},
    '{1'b1, 21'h300,  32'h0030_0400, 4'd4},   // R4
    '{1'b0, 21'h300,  32'h0030_0400, 4'd4},
    '{1'b1, 21'h508,  32'h00AA_BBCC, 4'd6},   // R6 entry 0
    '{1'b1, 21'h518,  32'h0011_2233, 4'd6},   // R6 entry 2
    '{1'b0, 21'h508,  32'h00AA_BBCC, 4'd6},
    '{1'b0, 21'h51C,  32'h0011_2233, 4'd6},
    '{1'b0, 21'h510,  32'h0000_0000, 4'd6},
    '{1'b1, 21'h1008, 32'hDEAD_BEEF, 4'd7},   // R7 index 1
    '{1'b0, 21'h100C, 32'h0000_BEEF, 4'd7},
    '{1'b1, 21'h1FF8, 32'h0000_1234, 4'd7},   // R7 index 511
    '{1'b0, 21'h1FF8, 32'h0000_1234, 4'd7},
    '{1'b1, 21'h808,  32'hFF10_2030, 4'd5},   // R5 index 1
    '{1'b0, 21'h808,  32'h0000_0000, 4'd5},
    '{1'b1, 21'h638,  32'h00AB_C123, 4'd8},   // R8
    '{1'b0, 21'h638,  32'h0000_0000, 4'd8},
    '{1'b1, 21'h400,  32'h0000_1000, 4'd8},
    '{1'b0, 21'h400,  32'h0000_0000, 4'd8},
    '{1'b0, 21'h004,  32'h0000_0000, 4'd9},   // R9 unmapped read
    '{1'b1, 21'h108,  32'hFFFF_FFFF, 4'd9},
    '{1'b0, 21'h118,  32'h0000_0140, 4'd9},
    '{1'b0, 21'h150,  32'h0000_03C0, 4'd9}
  };

  localparam logic [20:0] TIMING_ADDRS [14] = '{
    21'h000, 21'h108, 21'h110, 21'h120, 21'h128, 21'h130, 21'h138,
    21'h140, 21'h148, 21'h158, 21'h160, 21'h168, 21'h170, 21'h200
  };

  logic        clk, rst_n;
  logic        bus_valid, bus_write, refresh_raise;
  logic [20:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid, irq, redraw;
  logic [7:0]  pix_index;
  logic [23:0] pix_rgb, csr_rgb;
  logic [8:0]  pat_index;
  logic [15:0] pat_word;
  logic [1:0]  csr_sel;
  logic [13:0] width_px, height_px;
  logic [31:0] ctrl_word, screen_start;
  logic [4:0]  pix_depth;
  logic        force_blank, cursor_on;
  logic [11:0] cursor_x, cursor_y;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fbctl_regs dut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .refresh_raise(refresh_raise), .irq(irq), .redraw(redraw),
    .pix_index(pix_index), .pix_rgb(pix_rgb),
    .pat_index(pat_index), .pat_word(pat_word),
    .csr_sel(csr_sel), .csr_rgb(csr_rgb),
    .width_px(width_px), .height_px(height_px), .ctrl_word(ctrl_word),
    .pix_depth(pix_depth), .force_blank(force_blank), .cursor_on(cursor_on),
    .cursor_x(cursor_x), .cursor_y(cursor_y), .screen_start(screen_start)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_depth(input logic [2:0] s);
    case (s)
      3'd0: return 32'd1;   3'd1: return 32'd2;
      3'd2: return 32'd4;   3'd3: return 32'd8;
      3'd4: return 32'd15;  3'd5: return 32'd16;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [20:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [20:0] a, output logic [31:0] d, output logic v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; v = bus_rvalid;
    bus_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10: watchdog expired, actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic        rv;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_wdata = '0; refresh_raise = 1'b0;
    pix_index = 8'd1; pat_index = 9'd511; csr_sel = 2'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 redraw", 32'(redraw), 0);
    chk("R1 rvalid", 32'(bus_rvalid), 0);
    chk("R1 width", 32'(width_px), 0);
    chk("R1 ctrl", ctrl_word, 0);
    chk("R1 depth", 32'(pix_depth), 1);
    chk("R1 cursor_on", 32'(cursor_on), 1);
    chk("R1 pix_rgb", 32'(pix_rgb), 0);

    // table walk
    foreach (VECS[i]) begin
      if (VECS[i].wr) begin
        bus_wr(VECS[i].addr, VECS[i].data);
      end else begin
        bus_rd(VECS[i].addr, rd, rv);
        chk($sformatf("R%0d read %h", VECS[i].req, VECS[i].addr), rd, VECS[i].data);
      end
    end

    // R10 read timing
    bus_rd(21'h300, rd, rv);
    chk("R10 rvalid after read", 32'(rv), 1);
    @(negedge clk);
    chk("R10 rvalid drops", 32'(bus_rvalid), 0);

    // exported settings
    chk("R2 width_px", 32'(width_px), 32'h500);
    chk("R3 height_px", 32'(height_px), 32'h1E0);
    chk("R4 depth sel 3", 32'(pix_depth), exp_depth(3'd3));
    chk("R4 blank", 32'(force_blank), 1);
    chk("R4 cursor_on", 32'(cursor_on), 1);
    bus_wr(21'h300, 32'h00C0_0000);
    chk("R4 depth sel 4", 32'(pix_depth), exp_depth(3'd4));
    chk("R4 cursor off", 32'(cursor_on), 0);
    chk("R4 blank off", 32'(force_blank), 0);
    bus_wr(21'h300, 32'h0060_0000);
    chk("R4 depth sel 6", 32'(pix_depth), exp_depth(3'd6));
    chk("R5 pix_rgb idx1", 32'(pix_rgb), 32'h102030);
    pix_index = 8'd0; #1;
    chk("R5 pix_rgb idx0", 32'(pix_rgb), 0);
    chk("R6 csr_rgb sel2", 32'(csr_rgb), 32'h112233);
    csr_sel = 2'd3; #1;
    chk("R6 csr_rgb sel3", 32'(csr_rgb), 0);
    chk("R7 pat_word 511", 32'(pat_word), 32'h1234);
    chk("R8 cursor_x", 32'(cursor_x), 32'hABC);
    chk("R8 cursor_y", 32'(cursor_y), 32'h123);
    chk("R8 screen_start", screen_start, 32'h1000);
    pix_index = 8'd1; csr_sel = 2'd2;
    @(negedge clk);

    // R9 timing addresses ignored
    foreach (TIMING_ADDRS[i]) begin
      bus_wr(TIMING_ADDRS[i], 32'hFFFF_FFFF);
      chk("R9 no redraw", 32'(redraw), 0);
    end
    chk("R9 width kept", 32'(width_px), 32'h500);
    chk("R9 height kept", 32'(height_px), 32'h1E0);
    chk("R9 ctrl kept", ctrl_word, 32'h0060_0000);
    chk("R9 start kept", screen_start, 32'h1000);
    chk("R9 cursor kept", {8'h0, cursor_x, cursor_y}, 32'hABC123);
    chk("R9 pal kept", 32'(pix_rgb), 32'h102030);

    // R11 interrupt
    refresh_raise = 1'b1; @(negedge clk); refresh_raise = 1'b0;
    chk("R11 irq set", 32'(irq), 1);
    @(negedge clk);
    chk("R11 irq held", 32'(irq), 1);
    bus_wr(21'h108, 32'h0);
    chk("R11 write lowers", 32'(irq), 0);
    refresh_raise = 1'b1; bus_wr(21'h118, 32'h140); refresh_raise = 1'b0;
    chk("R11 write wins", 32'(irq), 0);

    // R13 redraw
    chk("R13 no redraw on width", 32'(redraw), 0);
    bus_wr(21'h638, 32'h00AB_C123);
    chk("R13 no redraw on cursor pos", 32'(redraw), 0);
    bus_wr(21'h300, 32'h0060_0000);
    chk("R13 redraw on ctrl", 32'(redraw), 1);
    @(negedge clk);
    chk("R13 redraw one cycle", 32'(redraw), 0);
    bus_wr(21'h1000, 32'h5);
    chk("R13 redraw on pattern", 32'(redraw), 1);

    // R12 full reset
    refresh_raise = 1'b1; @(negedge clk); refresh_raise = 1'b0;
    bus_wr(21'h10_0000, 32'h0);
    chk("R13 redraw on reset", 32'(redraw), 1);
    chk("R12 irq", 32'(irq), 0);
    chk("R12 width", 32'(width_px), 0);
    chk("R12 height", 32'(height_px), 0);
    chk("R12 ctrl", ctrl_word, 0);
    chk("R12 start", screen_start, 0);
    chk("R12 cursor", {8'h0, cursor_x, cursor_y}, 0);
    chk("R12 pal", 32'(pix_rgb), 0);
    chk("R12 cpal", 32'(csr_rgb), 0);
    chk("R12 pattern", 32'(pat_word), 0);
    bus_rd(21'h508, rd, rv);
    chk("R12 cpal read", rd, 0);

    finish_run();
  end

endmodule